// File: doc/BRIEF.md
# Handshake Sequence Implication Monitor

This block is a synthesizable run-time checker placed beside a request/acknowledge/write handshake. It follows one attempt at a time through a two-part temporal rule. The triggering part is a run of one or more cycles with the request high, then one acknowledge cycle, then exactly a fixed number of consecutive write cycles (four by default). The obligation part starts on the following cycle. It allows any number of cycles where wait is high and request is low, and it must end with a cycle where done is high.

If the triggering part stops matching before it completes, the monitor returns to idle without a report. A broken obligation raises a one-cycle fail pulse. A completed obligation raises a one-cycle pass pulse. An abort input drops the attempt in progress with no verdict. A status flag shows whether an attempt is being tracked.

Top module: `seq_impl_monitor`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, pass_o, fail_o and active_o are all 0.
- R2: When idle, a sampled cycle with req_i high (and abort_i low) makes active_o 1 after that clock edge.
- R3: During the request run, a cycle with req_i high keeps the attempt in that run, even when ack_i is also high. A cycle with req_i low and ack_i high moves it to write counting. A cycle with both low returns it silently to idle: active_o goes to 0 and fail_o stays 0.
- R4: Write counting needs exactly WR_LEN (default 4) consecutive cycles with wr_i high. A cycle with wr_i low before the count completes returns silently to idle. The obligation begins only after the last write cycle, so an extra write cycle in place of wait or done is a violation.
- R5: The obligation is checked from the cycle after the last write. A done_i cycle there, with zero wait cycles before it, passes.
- R6: Any number of cycles with wait_i high and req_i low keep the obligation open with no verdict. A later done_i cycle passes.
- R7: An obligation cycle with done_i low that is not (wait_i high and req_i low) produces a fail. This includes wait_i high together with req_i high.
- R8: In an obligation cycle, done_i high wins over wait_i and over req_i, and the attempt passes.
- R9: abort_i high in any cycle returns the monitor to idle with no pass or fail, even when done_i is high in the same cycle.
- R10: pass_o and fail_o are registered pulses one cycle wide, never high together. active_o is 0 in the cycle a pulse is high. In that cycle req_i may start a new attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Drop the current attempt with no verdict |
| req_i | input | 1 | Request term of the handshake |
| ack_i | input | 1 | Acknowledge term |
| wr_i | input | 1 | Write term |
| wait_i | input | 1 | Wait term of the obligation |
| done_i | input | 1 | Completion term of the obligation |
| pass_o | output | 1 | One-cycle pulse: obligation met |
| fail_o | output | 1 | One-cycle pulse: obligation broken |
| active_o | output | 1 | An attempt is being tracked |

## Verification
In an obligation cycle, the verdict logic and the abort path can both act. The bench drives done_i and abort_i high in the same obligation cycle and expects no pass pulse and a low active flag afterwards. In another obligation cycle it drives done_i and wait_i together, which must pass. The scoreboard also looks at the cycle after each verdict, so it catches a pulse that lasts too long or a new attempt that starts when it should not.

// File: rtl/seqmon_pkg.sv
package seqmon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_WR   = 2'd2,
        PH_OBL  = 2'd3
    } phase_t;

    typedef struct packed {
        logic pass;
        logic fail;
    } verdict_t;

endpackage

// File: rtl/seqmon_write_counter.sv
module seqmon_write_counter #(
    parameter int WR_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(WR_LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (step) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CW'(WR_LEN - 1));

    // counter must never run past the final write slot
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(WR_LEN)); // R4

endmodule

// File: rtl/seqmon_phase_fsm.sv
module seqmon_phase_fsm
    import seqmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     abort_i,
    input  logic     req_i,
    input  logic     ack_i,
    input  logic     wr_i,
    input  logic     wait_i,
    input  logic     done_i,
    input  logic     wr_last,
    output logic     cnt_step,
    output verdict_t hit,
    output phase_t   phase_q
);
    typedef struct packed {
        phase_t   phase;
        verdict_t hit;
    } fsm_next_t;

    fsm_next_t nx_d;
    phase_t    phase_d;

    always_comb begin
        nx_d.phase    = phase_q;
        nx_d.hit.pass = 1'b0;
        nx_d.hit.fail = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_i) nx_d.phase = PH_REQ;
            end
            PH_REQ: begin
                if (req_i)      nx_d.phase = PH_REQ;
                else if (ack_i) nx_d.phase = PH_WR;
                else            nx_d.phase = PH_IDLE;
            end
            PH_WR: begin
                if (!wr_i)        nx_d.phase = PH_IDLE;
                else if (wr_last) nx_d.phase = PH_OBL;
            end
            PH_OBL: begin
                if (done_i) begin
                    nx_d.phase    = PH_IDLE;
                    nx_d.hit.pass = 1'b1;
                end else if (wait_i && !req_i) begin
                    nx_d.phase = PH_OBL;
                end else begin
                    nx_d.phase    = PH_IDLE;
                    nx_d.hit.fail = 1'b1;
                end
            end
            default: nx_d.phase = PH_IDLE;
        endcase
        if (abort_i) begin
            nx_d.phase = PH_IDLE;
            nx_d.hit   = '0;
        end
    end

    assign phase_d  = nx_d.phase;
    assign hit      = nx_d.hit;
    assign cnt_step = (phase_q == PH_WR) && wr_i && !wr_last && !abort_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // the obligation phase is only reachable through the write phase
    AST_OBL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_OBL && phase_q != PH_WR) |=> phase_q != PH_OBL); // R4

    // abort leaves no attempt behind
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> phase_q == PH_IDLE); // R9

endmodule

// File: rtl/seqmon_verdict_reg.sv
module seqmon_verdict_reg
    import seqmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_t hit,
    output logic     pass_o,
    output logic     fail_o
);
    verdict_t v_d, v_q;

    always_comb begin
        v_d = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign pass_o = v_q.pass;
    assign fail_o = v_q.fail;

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o)); // R10

    AST_PASS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |=> !pass_o); // R10

    AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o); // R10

endmodule

// File: rtl/seq_impl_monitor.sv
module seq_impl_monitor
    import seqmon_pkg::*;
#(
    parameter int WR_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_i,
    input  logic req_i,
    input  logic ack_i,
    input  logic wr_i,
    input  logic wait_i,
    input  logic done_i,
    output logic pass_o,
    output logic fail_o,
    output logic active_o
);
    logic     wr_last;
    logic     cnt_step;
    verdict_t hit;
    phase_t   phase_q;

    seqmon_write_counter #(.WR_LEN(WR_LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cnt_step),
        .last  (wr_last)
    );

    seqmon_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort_i  (abort_i),
        .req_i    (req_i),
        .ack_i    (ack_i),
        .wr_i     (wr_i),
        .wait_i   (wait_i),
        .done_i   (done_i),
        .wr_last  (wr_last),
        .cnt_step (cnt_step),
        .hit      (hit),
        .phase_q  (phase_q)
    );

    seqmon_verdict_reg u_vrd (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .pass_o (pass_o),
        .fail_o (fail_o)
    );

    assign active_o = (phase_q != PH_IDLE);

    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && req_i && !abort_i) |=> active_o); // R2

    AST_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o || fail_o) |-> !active_o); // R10

    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!pass_o && !fail_o && !active_o)); // R9

endmodule

// File: tb/seq_impl_monitor_tb.sv
module seq_impl_monitor_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic abort_i = 1'b0, req_i = 1'b0, ack_i = 1'b0, wr_i = 1'b0;
    logic wait_i = 1'b0, done_i = 1'b0;
    logic pass_o, fail_o, active_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic  p;
        logic  f;
        logic  a;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    seq_impl_monitor #(.WR_LEN(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .req_i(req_i),
        .ack_i(ack_i), .wr_i(wr_i), .wait_i(wait_i), .done_i(done_i),
        .pass_o(pass_o), .fail_o(fail_o), .active_o(active_o)
    );

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    endtask

    // driver: apply one cycle of stimulus and queue the outputs expected after the edge
    task automatic cyc(input logic r, input logic a, input logic w, input logic wt,
                       input logic d, input logic ab,
                       input logic ep, input logic ef, input logic ea, input string tag);
        exp_t e;
        @(negedge clk);
        req_i = r; ack_i = a; wr_i = w; wait_i = wt; done_i = d; abort_i = ab;
        e.p = ep; e.f = ef; e.a = ea; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic trigger(input int nreq, input string tag);
        for (int i = 0; i < nreq; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 1, tag);
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 1, tag);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, tag);
    endtask

    // monitor: compare outputs shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (pass_o !== e.p || fail_o !== e.f || active_o !== e.a) begin
                    errors++;
                    $display("FAIL %s: actual pass=%b fail=%b active=%b expected pass=%b fail=%b active=%b",
                             e.tag, pass_o, fail_o, active_o, e.p, e.f, e.a);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        checks++;
        if (pass_o !== 0 || fail_o !== 0 || active_o !== 0) begin
            errors++;
            $display("FAIL R1 in reset: actual %b%b%b expected 000", pass_o, fail_o, active_o);
        end
        req_i = 1'b0;
        rst_n = 1'b1;
        idle("R1 after release");

        // R2 R3 R4 R5: minimal trigger, zero waits
        trigger(1, "R2 R3 R4 trigger");
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 0, "R5 done right away");
        idle("R10 pass lasts one cycle");

        // R6: several waits, then done
        trigger(3, "R3 long req run");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R6 wait keeps open");
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 0, "R6 done after waits");
        idle("R6 after pass");

        // R7: empty cycle breaks the obligation
        trigger(1, "R7 trigger");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R7 wait");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R7 empty cycle fails");
        idle("R10 fail lasts one cycle");

        // R7: wait together with req is a violation
        trigger(1, "R7 trigger b");
        cyc(1, 0, 0, 1, 0, 0, 0, 1, 0, "R7 wait with req fails");
        idle("R7 after fail");

        // R8: done and wait together pass
        trigger(1, "R8 trigger");
        cyc(0, 0, 0, 1, 1, 0, 1, 0, 0, "R8 done beats wait");
        idle("R8 after pass");

        // R3: silent drops and req+ack priority
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 ack alone does not start");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 1, "R2 start");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 both low drops silently");
        idle("R3 no late fail");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 1, "R3 start");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 1, "R3 req with ack stays in run");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 1, "R3 ack alone");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, "R3 writes");
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 0, "R3 pass after req+ack cycle");
        idle("R3 after pass");

        // R4: short write run drops silently; extra write fails
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 1, "R4 start");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 1, "R4 ack");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, "R4 write 1");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, "R4 write 2");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 write gap drops silently");
        idle("R4 no fail after drop");
        trigger(1, "R4 trigger");
        cyc(0, 0, 1, 0, 0, 0, 0, 1, 0, "R4 fifth write fails");
        idle("R4 after fail");

        // R9: abort with done in the same cycle, and abort during writes
        trigger(1, "R9 trigger");
        cyc(0, 0, 0, 1, 1, 1, 0, 0, 0, "R9 abort beats done");
        idle("R9 no late verdict");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 1, "R9 start");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 1, "R9 ack");
        cyc(0, 0, 1, 0, 0, 1, 0, 0, 0, "R9 abort during writes");
        idle("R9 after abort");

        // R10: req in the verdict cycle is ignored, next req starts
        trigger(1, "R10 trigger");
        cyc(1, 0, 0, 0, 1, 0, 1, 0, 0, "R10 done with req passes");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 1, "R10 new attempt in pulse cycle");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 new attempt drops");
        idle("R10 final idle");

        @(posedge clk);
        #3;
        report();
    end

endmodule